// File: doc/BRIEF.md
# Epoch-Offset Seconds Clock

This block keeps a 32-bit count of seconds since 1 January 1904 and answers two byte-oriented commands: one reads the count as four bytes, most significant first, and one replaces it with four argument bytes, also most significant first. A clock-enable prescaler divides the input clock by `CLK_HZ`, so the count advances once per second, and the same enable leaves the block as a one-cycle tick for interrupt logic.

After reset the count holds `INIT_UNIX + 2082844800`, which turns a Unix-epoch seconds value into the 1904 epoch. A command is taken in the cycle in which `cmd_valid` and `cmd_ready` are both high. The response comes one cycle later and lasts one cycle. The controller is a four-state machine. From `ST_IDLE`, an accepted read with a correct length moves to `ST_REPLY_READ`, an accepted load with a correct length moves to `ST_REPLY_LOAD`, and any command with the wrong length moves to `ST_REPLY_REJECT`. All three reply states return to `ST_IDLE` unconditionally on the next edge.

Top module: `rtc_epoch_clock`

## Requirements
- R1: After reset the count is `INIT_UNIX + 2082844800`, `cmd_ready` is 1, and `rsp_valid` and `sec_tick` are 0.
- R2: `sec_tick` is high for exactly one cycle out of every `CLK_HZ`, with no drift. The count increases by one on the edge that ends each tick cycle.
- R3: A read (`cmd_op`=0) with `arg_len`=0 produces, in the next cycle only, `rsp_valid`=1 and `rsp_len`=4. `rsp_bytes` then holds the count from the accepting cycle, with byte 0 (bits 7:0) the most significant.
- R4: A load (`cmd_op`=1) with `arg_len`=4 writes the count on the accepting edge. The new count is `arg_bytes` with byte 0 (bits 7:0) as its most significant byte. The reply has `rsp_len`=0.
- R5: A load restarts the prescaler, so the next tick comes in the `CLK_HZ`-th cycle after the load edge.
- R6: A read with nonzero length, or a load whose length is not 4, leaves the count and the prescaler untouched. It still gets a reply with `rsp_len`=0 and `rsp_bytes`=0.
- R7: While a reply is shown, `cmd_ready` is 0 and any command presented is ignored.
- R8: The count wraps from 0xFFFFFFFF to 0.
- R9: A load accepted in a tick cycle wins over the increment, so the count equals the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 = read count, 1 = load count |
| arg_len | input | LEN_W | Number of argument bytes supplied |
| arg_bytes | input | 32 | Argument bytes, byte i at bits 8i+7:8i |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| rsp_valid | output | 1 | Reply present (one cycle) |
| rsp_len | output | 3 | Reply byte count (4 or 0) |
| rsp_bytes | output | 32 | Reply bytes, byte i at bits 8i+7:8i |
| sec_tick | output | 1 | One-second pulse |

## Verification
The bench builds the block with `CLK_HZ`=8 and `INIT_UNIX`=100, so a full second takes only eight cycles. This puts many ticks, the prescaler restart, a load that lands exactly on a tick cycle, and the 32-bit wrap within a few hundred cycles. A cycle-level model of the count and prescaler phase runs beside the design. Every read is compared with that model, and the tick pin is compared with the model's phase on every cycle.

// File: rtl/rtc_epoch_pkg.sv
package rtc_epoch_pkg;
    localparam int SEC_W     = 32;
    localparam int RSP_BYTES = SEC_W / 8;
    localparam int RSP_LEN_W = $clog2(RSP_BYTES + 1);
    localparam logic [SEC_W-1:0] EPOCH_SHIFT = 32'd2082844800;

    typedef enum logic {
        OP_READ = 1'b0,
        OP_LOAD = 1'b1
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REPLY_READ,
        ST_REPLY_LOAD,
        ST_REPLY_REJECT
    } ctl_state_e;
endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
    parameter int unsigned CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick
);
    localparam int CNT_W = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

    logic [CNT_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign sec_tick = (phase == LAST);

    // Independent gap counter: cycles since the last tick or restart.
    logic [31:0] gap;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (restart || sec_tick) begin
            gap <= '0;
        end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 32'd1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> gap == 32'(CLK_HZ - 1)); // R2
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sec_tick); // R5
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_epoch_pkg::*;
#(
    parameter logic [SEC_W-1:0] INIT_UNIX = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec_now
);
    localparam logic [SEC_W-1:0] RESET_SECS = INIT_UNIX + EPOCH_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_now <= RESET_SECS;
        end else if (load_en) begin
            sec_now <= load_val;
        end else if (sec_tick) begin
            sec_now <= sec_now + 1'b1;
        end
    end

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_en) |=> sec_now == $past(sec_now) + 1'b1); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> sec_now == $past(load_val)); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !load_en) |=> $stable(sec_now)); // R6
endmodule

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl
    import rtc_epoch_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_op,
    input  logic [LEN_W-1:0]       arg_len,
    input  logic [8*RSP_BYTES-1:0] arg_bytes,
    input  logic [SEC_W-1:0]       sec_now,
    output logic                   load_en,
    output logic [SEC_W-1:0]       load_val,
    output logic                   cmd_ready,
    output logic                   rsp_valid,
    output logic [RSP_LEN_W-1:0]   rsp_len,
    output logic [8*RSP_BYTES-1:0] rsp_bytes
);
    localparam logic [LEN_W-1:0]     LOAD_LEN = LEN_W'(RSP_BYTES);
    localparam logic [RSP_LEN_W-1:0] READ_LEN = RSP_LEN_W'(RSP_BYTES);

    ctl_state_e state, state_nx;
    cmd_op_e    op;
    logic       accept;
    logic       len_ok;
    logic [SEC_W-1:0]       snap;
    logic [8*RSP_BYTES-1:0] snap_bytes;

    assign op     = cmd_op_e'(cmd_op);
    assign accept = cmd_valid && (state == ST_IDLE);
    assign len_ok = (op == OP_READ) ? (arg_len == '0) : (arg_len == LOAD_LEN);

    // Byte 0 of each buffer is the most significant byte of the count.
    for (genvar b = 0; b < RSP_BYTES; b++) begin : g_byte_order
        assign load_val[SEC_W-1-8*b -: 8] = arg_bytes[8*b +: 8];
        assign snap_bytes[8*b +: 8]       = snap[SEC_W-1-8*b -: 8];
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!len_ok)
                        state_nx = ST_REPLY_REJECT;
                    else if (op == OP_READ)
                        state_nx = ST_REPLY_READ;
                    else
                        state_nx = ST_REPLY_LOAD;
                end
            end
            ST_REPLY_READ:   state_nx = ST_IDLE;
            ST_REPLY_LOAD:   state_nx = ST_IDLE;
            ST_REPLY_REJECT: state_nx = ST_IDLE;
            default:         state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Snapshot of the count taken on an accepted read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap <= '0;
        else if (accept && len_ok && op == OP_READ)
            snap <= sec_now;
    end

    // Outputs
    always_comb begin
        load_en   = accept && len_ok && (op == OP_LOAD);
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_len   = '0;
        rsp_bytes = '0;
        unique case (state)
            ST_IDLE: cmd_ready = 1'b1;
            ST_REPLY_READ: begin
                rsp_valid = 1'b1;
                rsp_len   = READ_LEN;
                rsp_bytes = snap_bytes;
            end
            ST_REPLY_LOAD:   rsp_valid = 1'b1;
            ST_REPLY_REJECT: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    AST_REPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R7
    AST_LOAD_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (rsp_valid && rsp_len == '0)); // R4
    AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op == OP_READ && arg_len == '0)
        |=> (rsp_len == READ_LEN && snap == $past(sec_now))); // R3
    AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op == OP_LOAD && arg_len != LOAD_LEN)
        |-> !load_en); // R6
endmodule

// File: rtl/rtc_epoch_clock.sv
module rtc_epoch_clock
    import rtc_epoch_pkg::*;
#(
    parameter int unsigned      CLK_HZ    = 32768,
    parameter logic [SEC_W-1:0] INIT_UNIX = '0,
    parameter int               LEN_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_op,
    input  logic [LEN_W-1:0]       arg_len,
    input  logic [8*RSP_BYTES-1:0] arg_bytes,
    output logic                   cmd_ready,
    output logic                   rsp_valid,
    output logic [RSP_LEN_W-1:0]   rsp_len,
    output logic [8*RSP_BYTES-1:0] rsp_bytes,
    output logic                   sec_tick
);
    logic             load_en;
    logic [SEC_W-1:0] load_val;
    logic [SEC_W-1:0] sec_now;

    rtc_sec_prescaler #(.CLK_HZ(CLK_HZ)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (load_en),
        .sec_tick (sec_tick)
    );

    rtc_sec_counter #(.INIT_UNIX(INIT_UNIX)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load_en  (load_en),
        .load_val (load_val),
        .sec_now  (sec_now)
    );

    rtc_cmd_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .arg_len   (arg_len),
        .arg_bytes (arg_bytes),
        .sec_now   (sec_now),
        .load_en   (load_en),
        .load_val  (load_val),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_len   (rsp_len),
        .rsp_bytes (rsp_bytes)
    );

    AST_RESET_COUNT: assert property (@(posedge clk)
        $rose(rst_n) |-> sec_now == INIT_UNIX + EPOCH_SHIFT); // R1
endmodule

// File: tb/test_rtc_epoch_clock.sv
module test_rtc_epoch_clock;
    localparam int unsigned N    = 8;
    localparam logic [31:0] INIT = 32'd100;
    localparam logic [31:0] BASE = INIT + 32'd2082844800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [7:0]  arg_len = '0;
    logic [31:0] arg_bytes = '0;
    logic        cmd_ready, rsp_valid, sec_tick;
    logic [2:0]  rsp_len;
    logic [31:0] rsp_bytes;

    int n_chk = 0;
    int n_fail = 0;
    int tick_mismatch = 0;

    always #2.5 clk = ~clk;

    rtc_epoch_clock #(.CLK_HZ(N), .INIT_UNIX(INIT), .LEN_W(8)) i_rtc_epoch_clock (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .arg_len(arg_len), .arg_bytes(arg_bytes), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_bytes(rsp_bytes),
        .sec_tick(sec_tick)
    );

    // Reference model of count and prescaler phase
    logic [31:0] m_sec;
    int          m_pre;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sec <= BASE;
            m_pre <= 0;
        end else if (cmd_valid && cmd_ready && cmd_op && arg_len == 8'd4) begin
            m_sec <= {arg_bytes[7:0], arg_bytes[15:8], arg_bytes[23:16], arg_bytes[31:24]};
            m_pre <= 0;
        end else if (m_pre == N - 1) begin
            m_sec <= m_sec + 32'd1;
            m_pre <= 0;
        end else begin
            m_pre <= m_pre + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && (sec_tick !== (m_pre == N - 1))) tick_mismatch++;
    end

    function automatic logic [31:0] to_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input string req, output logic [31:0] got);
        logic [31:0] exp;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; arg_len = 8'd0;
        exp = m_sec;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "read rsp_valid", rsp_valid, 1);
        chk(req, "read rsp_len", rsp_len, 4);
        chk(req, "read rsp_bytes", rsp_bytes, to_bytes(exp));
        got = {rsp_bytes[7:0], rsp_bytes[15:8], rsp_bytes[23:16], rsp_bytes[31:24]};
    endtask

    task automatic do_load(input string req, input logic [31:0] val, input logic [7:0] len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b1; arg_len = len; arg_bytes = to_bytes(val);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, "load rsp_valid", rsp_valid, 1);
        chk(req, "load rsp_len", rsp_len, 0);
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        chk("R1", "cmd_ready", cmd_ready, 1);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "sec_tick", sec_tick, 0);
        do_read("R1", v);
        chk("R1", "reset count", v, BASE);
    endtask

    task automatic t_advance;
        logic [31:0] a, b;
        do_read("R3", a);
        repeat (3 * N - 1) @(negedge clk);
        do_read("R2", b);
        chk("R2", "three seconds elapsed", b - a, 3);
    endtask

    task automatic t_load_then_read;
        logic [31:0] v;
        do_load("R4", 32'h1234_5678, 8'd4);
        do_read("R4", v);
        chk("R4", "loaded value", v, 32'h1234_5678);
    endtask

    task automatic t_bad_lengths;
        logic [31:0] v;
        do_load("R6", 32'hDEAD_BEEF, 8'd3);
        do_load("R6", 32'hDEAD_BEEF, 8'd5);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; arg_len = 8'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6", "bad read rsp_valid", rsp_valid, 1);
        chk("R6", "bad read rsp_len", rsp_len, 0);
        chk("R6", "bad read rsp_bytes", rsp_bytes, 0);
        do_read("R6", v);
        chk("R6", "count untouched", v == 32'hDEAD_BEEF, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        do_load("R8", 32'hFFFF_FFFF, 8'd4);
        repeat (N) @(negedge clk);
        do_read("R8", v);
        chk("R8", "wrapped count", v, 32'h0000_0000);
    endtask

    task automatic t_restart_phase;
        int k;
        repeat (3) @(negedge clk);
        do_load("R5", 32'h0000_0040, 8'd4);
        k = 1;
        while (!sec_tick && k < 4 * N) begin
            @(negedge clk);
            k++;
        end
        chk("R5", "cycles to first tick after load", k, N);
    endtask

    task automatic t_load_on_tick;
        logic [31:0] v;
        do @(negedge clk); while (m_pre != N - 1);
        chk("R2", "tick high in tick cycle", sec_tick, 1);
        cmd_valid = 1'b1; cmd_op = 1'b1; arg_len = 8'd4; arg_bytes = to_bytes(32'h0000_7000);
        @(negedge clk);
        cmd_valid = 1'b0;
        do_read("R9", v);
        chk("R9", "load beats increment", v, 32'h0000_7000);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b1; arg_len = 8'd4; arg_bytes = to_bytes(32'h0000_0A00);
        @(negedge clk);
        chk("R7", "not ready during reply", cmd_ready, 0);
        arg_bytes = to_bytes(32'h0000_0B00);
        @(negedge clk);
        cmd_valid = 1'b0;
        do_read("R7", v);
        chk("R7", "second load ignored", v[31:8], 24'h00000A);
    endtask

    task automatic finish_run;
        chk("R2", "tick matches model", tick_mismatch, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_advance();
        t_load_then_read();
        t_bad_lengths();
        t_wrap();
        t_restart_phase();
        t_load_on_tick();
        t_busy_ignore();
        finish_run();
    end
endmodule